// File: doc/BRIEF.md
# Two-Stage 16-Bit Register-Operand Processor Core

A small 16-bit processor built as two stages. The front stage fetches one instruction word from an external program memory, decodes it, reads its source registers from a four-entry register file and places a decoded micro-operation into a two-entry queue. The back stage takes the oldest queued micro-operation and completes it. It writes the register file, decides a branch, or trades a word with the outside world over a 16-bit input port and a 16-bit output port. Each port uses a valid/ready handshake.

Source values are captured at decode, so a queued micro-operation never goes back to the register file. Correctness comes from holding the front stage: it does not advance while any queued micro-operation will still write a register that the candidate instruction reads. A branch is decided at the head of the queue. When it is taken, the program counter is redirected and every queued micro-operation is discarded in the same cycle.

Instruction word layout: bits [15:12] opcode, [11:10] field A, [9:8] field B, [7:6] field C, and [7:0] an 8-bit immediate. The opcodes are:

| Opcode | Mnemonic | Operation |
|---|---|---|
| 0 | LDI | A ← immediate |
| 1 | LDPC | A ← own address |
| 2 | ADD | A ← B + C |
| 3 | SUB | A ← B − C |
| 4 | BZ | if reg B == 0 then jump to reg A |
| 5 | OUT | send reg A on the output port |
| 6 | IN | A ← word from the input port |

Opcodes 7 to 15 are undefined.

Top module: `d16_core`

## Requirements
- R1: While reset is low and after it is released, the program counter reads 0, `out_valid` and `in_ready` are low, and all four registers read 0.
- R2: Each instruction accepted by the front stage advances the program counter by exactly one word.
- R3: LDI (opcode 0) writes the 8-bit immediate zero-extended to 16 bits into register A. LDPC (opcode 1) writes the instruction's own address into register A.
- R4: ADD (opcode 2) writes B+C and SUB (opcode 3) writes B−C into register A, both modulo 2^16.
- R5: The front stage holds its instruction and program counter while any queued micro-operation writes a register the instruction reads. The result then uses the updated value. With a dependent pair at addresses 0 and 1, the program counter is 1 after the second clock edge and 2 after the third.
- R6: The queue holds at most two micro-operations. When it is full the front stage holds, and fetch resumes once an entry leaves.
- R7: BZ (opcode 4, target register A, condition register B) with a zero condition loads the target into the program counter on the next edge and empties the queue. No instruction fetched in that cycle or queued behind it takes effect.
- R8: BZ with a nonzero condition has no effect besides being retired, and execution continues in sequence.
- R9: OUT (opcode 5) raises `out_valid` with register A's value on `out_data`. Both hold steady until `out_ready` is seen high at a clock edge, and exactly one word is transferred.
- R10: IN (opcode 6) raises `in_ready` while it is the oldest queued micro-operation. It writes `in_data` into register A at the first edge where `in_valid` is high. `in_ready` and `out_valid` are never both high.
- R11: An undefined opcode (7 to 15) is never accepted, so the program counter stays on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Word address of the instruction being fetched (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, combinational read |
| in_data | input | 16 | Input port word |
| in_valid | input | 1 | Input port word is present |
| in_ready | output | 1 | Core takes the input word at this edge if valid |
| out_data | output | 16 | Output port word |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Receiver takes the output word at this edge |

## Verification
The hardest state to reach from the ports is a full queue with a blocked head. Execution drains one micro-operation per cycle, so independent code never lets two entries pile up. The bench reaches this state with an OUT at address 0 while `out_ready` is held low. The independent loads behind it fill the queue, and the bench can then watch the program counter freeze and the output word stay stable. Branch redirection and hazard stalls are timed exactly by counting clock edges from the release of reset and comparing `imem_addr` against the cycle predicted from the requirements.

// File: rtl/d16_pkg.sv
package d16_pkg;
    localparam int XW   = 16;
    localparam int RW   = 2;
    localparam int NREG = 1 << RW;
    localparam int IMMW = 8;

    localparam logic [3:0] OP_LDI  = 4'd0;
    localparam logic [3:0] OP_LDPC = 4'd1;
    localparam logic [3:0] OP_ADD  = 4'd2;
    localparam logic [3:0] OP_SUB  = 4'd3;
    localparam logic [3:0] OP_BZ   = 4'd4;
    localparam logic [3:0] OP_OUT  = 4'd5;
    localparam logic [3:0] OP_IN   = 4'd6;

    typedef enum logic [2:0] {K_MOV, K_ADD, K_SUB, K_BZ, K_OUT, K_IN} kind_e;

    typedef struct packed {
        kind_e           kind;
        logic [RW-1:0]   dst;
        logic [XW-1:0]   v1;
        logic [XW-1:0]   v2;
    } uop_t;

    typedef logic [NREG-1:0][XW-1:0] rfile_t;

    function automatic logic uop_writes(kind_e k);
        return (k == K_MOV) || (k == K_ADD) || (k == K_SUB) || (k == K_IN);
    endfunction
endpackage

// File: rtl/d16_queue.sv
module d16_queue import d16_pkg::*; #(
    parameter int DEPTH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq,
    input  uop_t             enq_uop,
    input  logic             deq,
    input  logic             flush,
    output uop_t             slot [DEPTH],
    output logic [DEPTH-1:0] slot_vld,
    output logic             full,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        uop_t [DEPTH-1:0] slot;
        logic [CW-1:0]    cnt;
    } qst_t;

    qst_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.cnt = '0;
        end else begin
            if (deq) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    q_d.slot[i] = q_q.slot[i+1];
                end
                q_d.cnt = q_q.cnt - 1'b1;
            end
            if (enq) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == q_d.cnt) q_d.slot[i] = enq_uop;
                end
                q_d.cnt = q_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot[g]     = q_q.slot[g];
        assign slot_vld[g] = CW'(g) < q_q.cnt;
    end

    assign full  = (q_q.cnt == CW'(DEPTH));
    assign count = q_q.cnt;
endmodule

// File: rtl/d16_fetch.sv
module d16_fetch import d16_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic [XW-1:0]    pc,
    input  logic [XW-1:0]    instr,
    input  rfile_t           rf,
    input  uop_t             slot [DEPTH],
    input  logic [DEPTH-1:0] slot_vld,
    input  logic             q_full,
    input  logic             flush,
    output logic             go,
    output uop_t             uop
);
    logic [3:0]    op;
    logic [RW-1:0] fa, fb, fc;
    logic          use_a, use_b, use_c, legal, hazard;

    assign op = instr[15:12];
    assign fa = instr[11:10];
    assign fb = instr[9:8];
    assign fc = instr[7:6];

    always_comb begin
        uop     = '0;
        uop.dst = fa;
        use_a   = 1'b0;
        use_b   = 1'b0;
        use_c   = 1'b0;
        legal   = 1'b1;
        case (op)
            OP_LDI: begin
                uop.kind = K_MOV;
                uop.v1   = XW'(instr[IMMW-1:0]);
            end
            OP_LDPC: begin
                uop.kind = K_MOV;
                uop.v1   = pc;
            end
            OP_ADD, OP_SUB: begin
                uop.kind = (op == OP_ADD) ? K_ADD : K_SUB;
                uop.v1   = rf[fb];
                uop.v2   = rf[fc];
                use_b    = 1'b1;
                use_c    = 1'b1;
            end
            OP_BZ: begin
                uop.kind = K_BZ;
                uop.v1   = rf[fa];
                uop.v2   = rf[fb];
                use_a    = 1'b1;
                use_b    = 1'b1;
            end
            OP_OUT: begin
                uop.kind = K_OUT;
                uop.v1   = rf[fa];
                use_a    = 1'b1;
            end
            OP_IN: begin
                uop.kind = K_IN;
            end
            default: legal = 1'b0;
        endcase
    end

    always_comb begin
        hazard = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_vld[i] && uop_writes(slot[i].kind)) begin
                if ((use_a && slot[i].dst == fa) ||
                    (use_b && slot[i].dst == fb) ||
                    (use_c && slot[i].dst == fc)) begin
                    hazard = 1'b1;
                end
            end
        end
    end

    assign go = legal && !hazard && !q_full && !flush;
endmodule

// File: rtl/d16_exec.sv
module d16_exec import d16_pkg::*; (
    input  uop_t          head,
    input  logic          head_vld,
    input  logic [XW-1:0] in_data,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          deq,
    output logic          flush,
    output logic [XW-1:0] br_target,
    output logic          wr_en,
    output logic [RW-1:0] wr_idx,
    output logic [XW-1:0] wr_val,
    output logic          out_valid,
    output logic [XW-1:0] out_data,
    output logic          in_ready
);
    always_comb begin
        deq       = 1'b0;
        flush     = 1'b0;
        wr_en     = 1'b0;
        wr_val    = head.v1;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        if (head_vld) begin
            case (head.kind)
                K_MOV: begin
                    wr_en = 1'b1;
                    deq   = 1'b1;
                end
                K_ADD: begin
                    wr_en  = 1'b1;
                    wr_val = head.v1 + head.v2;
                    deq    = 1'b1;
                end
                K_SUB: begin
                    wr_en  = 1'b1;
                    wr_val = head.v1 - head.v2;
                    deq    = 1'b1;
                end
                K_BZ: begin
                    if (head.v2 == '0) flush = 1'b1;
                    else               deq   = 1'b1;
                end
                K_OUT: begin
                    out_valid = 1'b1;
                    deq       = out_ready;
                end
                K_IN: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        wr_en  = 1'b1;
                        wr_val = in_data;
                        deq    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_idx    = head.dst;
    assign br_target = head.v1;
    assign out_data  = head.v1;
endmodule

// File: rtl/d16_core.sv
module d16_core import d16_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] imem_addr,
    input  logic [XW-1:0] imem_data,
    input  logic [XW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [XW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [XW-1:0] pc;
        rfile_t        rf;
    } core_st_t;

    core_st_t st_q, st_d;

    uop_t             slot [DEPTH];
    logic [DEPTH-1:0] slot_vld;
    logic             q_full;
    logic [CW-1:0]    q_cnt;
    logic             fetch_go;
    uop_t             fetch_uop;
    logic             deq, flush, wr_en;
    logic [XW-1:0]    br_target, wr_val;
    logic [RW-1:0]    wr_idx;

    d16_fetch #(.DEPTH(DEPTH)) u_fetch (
        .pc       (st_q.pc),
        .instr    (imem_data),
        .rf       (st_q.rf),
        .slot     (slot),
        .slot_vld (slot_vld),
        .q_full   (q_full),
        .flush    (flush),
        .go       (fetch_go),
        .uop      (fetch_uop)
    );

    d16_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq      (fetch_go),
        .enq_uop  (fetch_uop),
        .deq      (deq),
        .flush    (flush),
        .slot     (slot),
        .slot_vld (slot_vld),
        .full     (q_full),
        .count    (q_cnt)
    );

    d16_exec u_exec (
        .head      (slot[0]),
        .head_vld  (slot_vld[0]),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .deq       (deq),
        .flush     (flush),
        .br_target (br_target),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .out_valid (out_valid),
        .out_data  (out_data),
        .in_ready  (in_ready)
    );

    always_comb begin
        st_d = st_q;
        if (flush)         st_d.pc = br_target;
        else if (fetch_go) st_d.pc = st_q.pc + 1'b1;
        if (wr_en)         st_d.rf[wr_idx] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign imem_addr = st_q.pc;
endmodule

// File: rtl/d16_core_chk.sv
module d16_core_chk #(
    parameter int DEPTH = 2,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   pc,
    input logic          fetch_go,
    input logic          flush,
    input logic [CW-1:0] q_cnt,
    input logic          out_valid,
    input logic          out_ready,
    input logic [15:0]   out_data,
    input logic          in_ready
);
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(DEPTH)); // R6

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && fetch_go && !flush |=> pc == $past(pc) + 16'd1); // R2

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !fetch_go && !flush |=> $stable(pc)); // R5

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && flush |=> q_cnt == '0); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R10
endmodule

bind d16_core d16_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (imem_addr),
    .fetch_go  (fetch_go),
    .flush     (flush),
    .q_cnt     (q_cnt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .in_ready  (in_ready)
);

// File: tb/d16_core_bench.sv
module d16_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] imem_addr, imem_data, in_data, out_data;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [15:0] rom [256];
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    assign imem_data = rom[imem_addr[7:0]];

    d16_core u_d16_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    function automatic logic [15:0] i_ldi(logic [1:0] rd, logic [7:0] imm);
        return {4'd0, rd, 2'b00, imm};
    endfunction
    function automatic logic [15:0] i_ldpc(logic [1:0] rd);
        return {4'd1, rd, 10'd0};
    endfunction
    function automatic logic [15:0] i_alu(logic sub, logic [1:0] rd, logic [1:0] ra, logic [1:0] rb);
        return {(sub ? 4'd3 : 4'd2), rd, ra, rb, 6'd0};
    endfunction
    function automatic logic [15:0] i_bz(logic [1:0] rt, logic [1:0] rc);
        return {4'd4, rt, rc, 8'd0};
    endfunction
    function automatic logic [15:0] i_out(logic [1:0] rs);
        return {4'd5, rs, 10'd0};
    endfunction
    function automatic logic [15:0] i_in(logic [1:0] rd);
        return {4'd6, rd, 10'd0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 16'hF000;
    endtask

    task automatic hold_reset();
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = 16'h0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    task automatic take_out(input logic [15:0] exp, input string tag);
        int n = 0;
        while (!out_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(out_valid && out_data == exp, tag, out_data, exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        clear_rom();
        rom[0] = i_out(2'd2);
        hold_reset();
        chk(imem_addr == 16'd0, "R1 pc in reset", imem_addr, 16'd0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
        chk(in_ready == 1'b0, "R1 in_ready in reset", {15'd0, in_ready}, 16'd0);
        release_reset();
        take_out(16'h0000, "R1 register cleared");
    endtask

    task automatic test_arith();
        clear_rom();
        rom[0] = i_ldi(2'd1, 8'hC8);
        rom[1] = i_ldi(2'd2, 8'h37);
        rom[2] = i_alu(1'b0, 2'd3, 2'd1, 2'd2);
        rom[3] = i_out(2'd3);
        rom[4] = i_alu(1'b1, 2'd0, 2'd2, 2'd1);
        rom[5] = i_out(2'd0);
        rom[6] = i_alu(1'b0, 2'd0, 2'd0, 2'd0);
        rom[7] = i_out(2'd0);
        rom[8] = i_ldpc(2'd1);
        rom[9] = i_out(2'd1);
        hold_reset();
        release_reset();
        take_out(16'h00FF, "R3 R4 zero-extended add");
        take_out(16'hFF6F, "R4 sub wraps");
        take_out(16'hFEDE, "R4 add wraps");
        take_out(16'h0008, "R3 load own address");
    endtask

    task automatic test_hazard();
        clear_rom();
        rom[0] = i_ldi(2'd1, 8'd5);
        rom[1] = i_alu(1'b0, 2'd2, 2'd1, 2'd1);
        rom[2] = i_out(2'd2);
        hold_reset();
        release_reset();
        repeat (2) @(negedge clk);
        chk(imem_addr == 16'd1, "R5 stall on pending write", imem_addr, 16'd1);
        @(negedge clk);
        chk(imem_addr == 16'd2, "R5 resume after write", imem_addr, 16'd2);
        take_out(16'd10, "R5 dependent result");
    endtask

    task automatic test_full();
        clear_rom();
        rom[0] = i_out(2'd0);
        rom[1] = i_ldi(2'd1, 8'd7);
        rom[2] = i_ldi(2'd2, 8'd8);
        rom[3] = i_ldi(2'd3, 8'd9);
        rom[4] = i_alu(1'b0, 2'd3, 2'd3, 2'd1);
        rom[5] = i_out(2'd3);
        hold_reset();
        release_reset();
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == 16'd0, "R9 output offered", out_data, 16'd0);
        repeat (3) @(negedge clk);
        chk(imem_addr == 16'd2, "R6 fetch held while full", imem_addr, 16'd2);
        chk(out_valid && out_data == 16'd0, "R9 output held", out_data, 16'd0);
        take_out(16'd0, "R9 first word");
        take_out(16'd16, "R9 R6 single transfer then resume");
    endtask

    task automatic test_taken();
        clear_rom();
        rom[0] = i_ldi(2'd1, 8'd6);
        rom[1] = i_ldi(2'd3, 8'h44);
        rom[2] = i_bz(2'd1, 2'd0);
        rom[3] = i_ldi(2'd3, 8'h99);
        rom[4] = i_out(2'd3);
        rom[6] = i_out(2'd3);
        rom[7] = i_ldpc(2'd2);
        rom[8] = i_out(2'd2);
        hold_reset();
        release_reset();
        repeat (4) @(negedge clk);
        chk(imem_addr == 16'd6, "R7 redirect", imem_addr, 16'd6);
        take_out(16'h0044, "R7 squashed load has no effect");
        take_out(16'h0007, "R7 continue at target");
    endtask

    task automatic test_not_taken();
        clear_rom();
        rom[0] = i_ldi(2'd1, 8'd9);
        rom[1] = i_ldi(2'd2, 8'd1);
        rom[2] = i_bz(2'd1, 2'd2);
        rom[3] = i_ldi(2'd3, 8'h33);
        rom[4] = i_out(2'd3);
        hold_reset();
        release_reset();
        take_out(16'h0033, "R8 fall through");
        repeat (3) @(negedge clk);
        chk(imem_addr == 16'd5, "R8 no redirect", imem_addr, 16'd5);
    endtask

    task automatic test_input();
        clear_rom();
        rom[0] = i_in(2'd1);
        rom[1] = i_alu(1'b0, 2'd2, 2'd1, 2'd1);
        rom[2] = i_out(2'd2);
        hold_reset();
        release_reset();
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b1, "R10 in_ready while waiting", {15'd0, in_ready}, 16'd1);
        chk(out_valid == 1'b0, "R10 no output while waiting", {15'd0, out_valid}, 16'd0);
        in_data  = 16'h1234;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'hFFFF;
        take_out(16'h2468, "R10 input word used");
    endtask

    task automatic test_halt();
        clear_rom();
        rom[0] = i_ldi(2'd0, 8'd3);
        rom[1] = 16'h7000;
        rom[2] = i_out(2'd0);
        hold_reset();
        release_reset();
        repeat (10) @(negedge clk);
        chk(imem_addr == 16'd1, "R11 pc stays on undefined opcode", imem_addr, 16'd1);
        chk(out_valid == 1'b0, "R11 nothing after undefined opcode", {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_arith();
        test_hazard();
        test_full();
        test_taken();
        test_not_taken();
        test_input();
        test_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule